// File: doc/BRIEF.md
# Frame-Synced PCM Serial Port

This block is a full-duplex serial port for telephony voice samples. Each direction has its own bit clock and its own 8 kHz frame sync, and the two directions frame on their own, with no timing relation between them. On each transmit frame start the port takes a parallel sample and shifts it out on a data pin, most significant bit first. On each receive frame start the port collects serial bits from a data pin and hands the finished word to the core with a one-cycle valid strobe.

The word length follows a two-bit mode input. The two companded modes use 8-bit words and the two linear modes use 14-bit words. Companding itself is done elsewhere. All external clocks, syncs and serial data are brought into the system clock domain through two-flop synchronizers. Their edges are then found by comparing each synchronized level with its value one cycle earlier. The system clock must run at least four times faster than the faster bit clock. Each bit clock may run from 128 kHz to 4.096 MHz, which gives 16 to 512 bit periods per frame.

Top module: `pcm_serial_port`

## Requirements
- R1: While reset is asserted and after it is released, tx_dout, tx_oe, rx_valid and rx_word are all zero until framing activity occurs.
- R2: The word length is latched from mode at each detected frame-sync rising edge. mode[1]=0 (00 A-law, 01 mu-law) selects 8 bits and mode[1]=1 selects 14 bits. In 8-bit mode the transmitted word is tx_word[7:0], and the received word sits in rx_word[7:0] with rx_word[13:8] zero.
- R3: The transmitter samples tx_word at the frame-sync rise. It drives the MSB on the first tx_bclk rising edge after that, and then one further bit on each later rising edge.
- R4: tx_oe is high while word bits are driven. On the tx_bclk rising edge after the last bit, tx_oe goes low and tx_dout goes to 0, and both stay there for the rest of the frame.
- R5: The receiver samples rx_din on each rx_bclk falling edge after a receive frame-sync rise, MSB first.
- R6: Once the final bit is captured, rx_valid pulses high for exactly one system clock with the word on rx_word. rx_word holds its value until the next completed word.
- R7: A frame sync that arrives mid-word restarts that direction. The transmitter starts again from the MSB of the newly sampled word, and the partial receive word is discarded without a valid pulse.
- R8: Transmit and receive framing are independent. Different bit rates and unrelated sync timing in the two directions do not affect each other's output.
- R9: Each external clock, sync and data input passes through a two-flop synchronizer and one edge-history flop, so an output reacts on the third system clock edge after the input change is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Word format select: 00/01 companded 8-bit, 10/11 linear 14-bit |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync (8 kHz) |
| tx_word | input | 14 | Sample to transmit, sampled at frame start |
| tx_dout | output | 1 | Transmit serial data |
| tx_oe | output | 1 | Transmit data enable (low means idle/high impedance) |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync (8 kHz) |
| rx_din | input | 1 | Receive serial data |
| rx_word | output | 14 | Last completed received word, right-justified |
| rx_valid | output | 1 | One-cycle strobe for a new rx_word |

## Verification
All four mode codes are run, and frames longer than the word show whether tx_oe drops after 8 bits or after 14, and whether 8-bit receive words are right-justified. Transmit and receive run concurrently at different bit rates, which would expose any crossing between the two directions. Frames cut short by an early sync separate a proper restart from a carried-over count or a stray valid pulse. A frame exactly one word long checks the boundary where the last bit meets the next sync. The reference model recomputes synchronizer latency from the pin history, so an extra or missing flop shows up as a one-cycle mismatch.

// File: rtl/pcm_sp_pkg.sv
package pcm_sp_pkg;

  localparam int unsigned PCM_LIN_BITS = 14;
  localparam int unsigned PCM_CMP_BITS = 8;

  typedef enum logic [1:0] {
    FMT_ALAW  = 2'b00,
    FMT_ULAW  = 2'b01,
    FMT_LIN_A = 2'b10,
    FMT_LIN_B = 2'b11
  } pcm_fmt_e;

  // linear formats have bit 1 set
  function automatic logic fmt_is_linear(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic int unsigned fmt_word_len(input logic [1:0] m,
                                               input int unsigned lin_bits,
                                               input int unsigned cmp_bits);
    return fmt_is_linear(m) ? lin_bits : cmp_bits;
  endfunction

endpackage

// File: rtl/pcm_sync_bus.sv
module pcm_sync_bus #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pcm_edge_det.sv
module pcm_edge_det #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse = prev_q & ~lvl;
    end else begin : g_rise
      assign pulse = lvl & ~prev_q;
    end
  endgenerate

endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcm_sp_pkg::*;
#(
  parameter int unsigned LIN_BITS = PCM_LIN_BITS,
  parameter int unsigned CMP_BITS = PCM_CMP_BITS,
  localparam int unsigned CNT_W   = $clog2(LIN_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fs_rise,
  input  logic                bclk_rise,
  input  logic [1:0]          mode,
  input  logic [LIN_BITS-1:0] word,
  output logic                dout,
  output logic                oe,
  output logic                shift_evt,
  output logic                idle_evt
);

  logic [LIN_BITS-1:0] shreg_q;
  logic [CNT_W-1:0]    remain_q;

  // companded samples are moved to the top so the MSB leaves first
  function automatic logic [LIN_BITS-1:0] align_word(input logic [LIN_BITS-1:0] w,
                                                     input logic lin);
    if (lin) return w;
    return {w[CMP_BITS-1:0], {(LIN_BITS-CMP_BITS){1'b0}}};
  endfunction

  assign shift_evt = bclk_rise & ~fs_rise & (remain_q != '0);
  assign idle_evt  = bclk_rise & ~fs_rise & (remain_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      remain_q <= '0;
      dout     <= 1'b0;
      oe       <= 1'b0;
    end else if (fs_rise) begin
      shreg_q  <= align_word(word, fmt_is_linear(mode));
      remain_q <= CNT_W'(fmt_word_len(mode, LIN_BITS, CMP_BITS));
    end else if (shift_evt) begin
      dout     <= shreg_q[LIN_BITS-1];
      oe       <= 1'b1;
      shreg_q  <= {shreg_q[LIN_BITS-2:0], 1'b0};
      remain_q <= remain_q - 1'b1;
    end else if (idle_evt) begin
      dout     <= 1'b0;
      oe       <= 1'b0;
    end
  end

  // R3
  oe_on_bclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $past(bclk_rise));

  // R4
  hold_between_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bclk_rise) |-> ($stable(dout) && $stable(oe)));

  // R4
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(idle_evt) |-> (!oe && !dout));

  // R7
  restart_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fs_rise) |-> ($stable(dout) && $stable(oe)));

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcm_sp_pkg::*;
#(
  parameter int unsigned LIN_BITS = PCM_LIN_BITS,
  parameter int unsigned CMP_BITS = PCM_CMP_BITS,
  localparam int unsigned CNT_W   = $clog2(LIN_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fs_rise,
  input  logic                bclk_fall,
  input  logic                din,
  input  logic [1:0]          mode,
  output logic [LIN_BITS-1:0] word,
  output logic                valid,
  output logic                capture_evt,
  output logic                last_evt
);

  logic                active_q;
  logic [CNT_W-1:0]    got_q;
  logic [CNT_W-1:0]    need_q;
  logic [LIN_BITS-1:0] acc_q;
  logic [LIN_BITS-1:0] acc_next;

  assign capture_evt = bclk_fall & ~fs_rise & active_q;
  assign last_evt    = capture_evt & ((got_q + 1'b1) == need_q);
  assign acc_next    = {acc_q[LIN_BITS-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      got_q    <= '0;
      need_q   <= '0;
      acc_q    <= '0;
      word     <= '0;
      valid    <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (fs_rise) begin
        active_q <= 1'b1;
        got_q    <= '0;
        acc_q    <= '0;
        need_q   <= CNT_W'(fmt_word_len(mode, LIN_BITS, CMP_BITS));
      end else if (capture_evt) begin
        acc_q <= acc_next;
        got_q <= got_q + 1'b1;
        if (last_evt) begin
          word     <= acc_next;
          valid    <= 1'b1;
          active_q <= 1'b0;
        end
      end
    end
  end

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R5
  valid_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(bclk_fall));

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(word));

  // R7
  restart_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fs_rise) |-> !valid);

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_sp_pkg::*;
#(
  parameter int unsigned LIN_BITS    = PCM_LIN_BITS,
  parameter int unsigned CMP_BITS    = PCM_CMP_BITS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode,
  input  logic                tx_bclk,
  input  logic                tx_fsync,
  input  logic [LIN_BITS-1:0] tx_word,
  output logic                tx_dout,
  output logic                tx_oe,
  input  logic                rx_bclk,
  input  logic                rx_fsync,
  input  logic                rx_din,
  output logic [LIN_BITS-1:0] rx_word,
  output logic                rx_valid
);

  localparam int unsigned NPINS = 5;
  localparam int unsigned P_TXB = 0;
  localparam int unsigned P_TXF = 1;
  localparam int unsigned P_RXB = 2;
  localparam int unsigned P_RXF = 3;
  localparam int unsigned P_RXD = 4;

  logic [NPINS-1:0] pins_async;
  logic [NPINS-1:0] pins_sync;

  logic tx_fs_rise, tx_bclk_rise;
  logic rx_fs_rise, rx_bclk_fall;
  logic tx_shift_evt, tx_idle_evt;
  logic rx_capture_evt, rx_last_evt;

  assign pins_async = {rx_din, rx_fsync, rx_bclk, tx_fsync, tx_bclk};

  pcm_sync_bus #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pins_async),
    .sync_out (pins_sync)
  );

  pcm_edge_det #(.FALLING(1'b0)) u_txf_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pins_sync[P_TXF]), .pulse(tx_fs_rise));
  pcm_edge_det #(.FALLING(1'b0)) u_txb_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pins_sync[P_TXB]), .pulse(tx_bclk_rise));
  pcm_edge_det #(.FALLING(1'b0)) u_rxf_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pins_sync[P_RXF]), .pulse(rx_fs_rise));
  pcm_edge_det #(.FALLING(1'b1)) u_rxb_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pins_sync[P_RXB]), .pulse(rx_bclk_fall));

  pcm_tx_lane #(.LIN_BITS(LIN_BITS), .CMP_BITS(CMP_BITS)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs_rise   (tx_fs_rise),
    .bclk_rise (tx_bclk_rise),
    .mode      (mode),
    .word      (tx_word),
    .dout      (tx_dout),
    .oe        (tx_oe),
    .shift_evt (tx_shift_evt),
    .idle_evt  (tx_idle_evt)
  );

  pcm_rx_lane #(.LIN_BITS(LIN_BITS), .CMP_BITS(CMP_BITS)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .fs_rise     (rx_fs_rise),
    .bclk_fall   (rx_bclk_fall),
    .din         (pins_sync[P_RXD]),
    .mode        (mode),
    .word        (rx_word),
    .valid       (rx_valid),
    .capture_evt (rx_capture_evt),
    .last_evt    (rx_last_evt)
  );

  // R8
  tx_events_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_shift_evt, tx_idle_evt, tx_fs_rise}));

  // R6
  rx_last_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_last_evt |=> rx_valid);

  // R9
  rx_capture_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_capture_evt |-> $past(pins_sync[P_RXB]) && !pins_sync[P_RXB]);

endmodule

// File: tb/sim_pcm_serial_port.sv
module sim_pcm_serial_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        tx_bclk = 1'b0, tx_fsync = 1'b0;
  logic [13:0] tx_word = '0;
  logic        tx_dout, tx_oe;
  logic        rx_bclk = 1'b0, rx_fsync = 1'b0, rx_din = 1'b0;
  logic [13:0] rx_word;
  logic        rx_valid;

  int nchk = 0;
  int nfail = 0;
  int nvalid = 0;

  always #10 clk = ~clk;

  pcm_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .tx_bclk(tx_bclk), .tx_fsync(tx_fsync), .tx_word(tx_word),
    .tx_dout(tx_dout), .tx_oe(tx_oe),
    .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .rx_din(rx_din),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // reference model: pin history per edge, bit queues, integer counters
  logic [3:0] h_tb, h_tf, h_rb, h_rf, h_rd;
  bit   txq[$];
  bit   m_dout, m_oe, m_valid, r_act;
  int   r_need, r_got, r_acc;
  logic [13:0] m_word;

  always @(posedge clk) begin
    if (!rst_n) begin
      h_tb = '0; h_tf = '0; h_rb = '0; h_rf = '0; h_rd = '0;
      txq.delete();
      m_dout = 0; m_oe = 0; m_valid = 0; r_act = 0;
      r_need = 0; r_got = 0; r_acc = 0; m_word = '0;
    end else begin
      h_tb = {h_tb[2:0], tx_bclk};
      h_tf = {h_tf[2:0], tx_fsync};
      h_rb = {h_rb[2:0], rx_bclk};
      h_rf = {h_rf[2:0], rx_fsync};
      h_rd = {h_rd[2:0], rx_din};
      if (h_tf[2] && !h_tf[3]) begin
        txq.delete();
        for (int i = (mode[1] ? 13 : 7); i >= 0; i--) txq.push_back(tx_word[i]);
      end else if (h_tb[2] && !h_tb[3]) begin
        if (txq.size() > 0) begin m_dout = txq.pop_front(); m_oe = 1; end
        else begin m_dout = 0; m_oe = 0; end
      end
      m_valid = 0;
      if (h_rf[2] && !h_rf[3]) begin
        r_act = 1; r_need = mode[1] ? 14 : 8; r_got = 0; r_acc = 0;
      end else if (!h_rb[2] && h_rb[3] && r_act) begin
        r_acc = (r_acc << 1) | int'(h_rd[2]);
        r_got++;
        if (r_got == r_need) begin
          m_word = r_acc[13:0]; m_valid = 1; r_act = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(tx_dout == m_dout, "R3 R9 tx_dout", tx_dout, m_dout);
      check(tx_oe == m_oe, "R4 R8 tx_oe", tx_oe, m_oe);
      check(rx_valid == m_valid, "R6 R7 rx_valid", rx_valid, m_valid);
      check(rx_word == m_word, "R5 R2 rx_word", rx_word, m_word);
      if (rx_valid) nvalid++;
    end
  end

  task automatic tx_frame(input logic [13:0] w, input int nper, input int half);
    tx_word = w; tx_fsync = 1'b1;
    repeat (half) @(negedge clk);
    for (int i = 0; i < nper; i++) begin
      tx_bclk = 1'b1;
      repeat (half) @(negedge clk);
      tx_fsync = 1'b0; tx_bclk = 1'b0;
      repeat (half) @(negedge clk);
    end
  endtask

  task automatic rx_frame(input logic [13:0] pat, input int nbits, input int nper, input int half);
    rx_fsync = 1'b1;
    repeat (half) @(negedge clk);
    for (int i = 0; i < nper; i++) begin
      rx_bclk = 1'b1;
      rx_din = (i < nbits) ? pat[nbits-1-i] : 1'b1;
      repeat (half) @(negedge clk);
      rx_fsync = 1'b0; rx_bclk = 1'b0;
      repeat (half) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int vbefore;
    repeat (3) @(negedge clk);
    // R1 outputs quiet in reset
    check(tx_dout == 0 && tx_oe == 0, "R1 tx in reset", {tx_dout, tx_oe}, 0);
    check(rx_valid == 0 && rx_word == 0, "R1 rx in reset", rx_word, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tx_oe == 0 && rx_valid == 0, "R1 after reset", {tx_oe, rx_valid}, 0);

    // R2 A-law 8-bit, frames longer than word; R8 distinct rates
    mode = 2'b00;
    fork
      tx_frame(14'h00A5, 16, 4);
      rx_frame(14'h003C, 8, 16, 5);
    join
    check(rx_word == 14'h003C, "R5 R2 alaw word", rx_word, 14'h003C);

    mode = 2'b01;
    fork
      tx_frame(14'h3F5A, 16, 5);
      rx_frame(14'h00C3, 8, 12, 4);
    join
    check(rx_word == 14'h00C3, "R2 mulaw word", rx_word, 14'h00C3);

    mode = 2'b10;
    fork
      tx_frame(14'h2B6D, 18, 4);
      rx_frame(14'h1ABC, 14, 16, 6);
    join
    check(rx_word == 14'h1ABC, "R5 linear word", rx_word, 14'h1ABC);

    // exact-length frames
    mode = 2'b11;
    fork
      tx_frame(14'h3001, 14, 4);
      rx_frame(14'h0FFF, 14, 14, 4);
    join
    check(rx_word == 14'h0FFF, "R6 exact frame word", rx_word, 14'h0FFF);

    // R7 early sync in both directions
    mode = 2'b10;
    vbefore = nvalid;
    fork
      begin tx_frame(14'h3FFF, 5, 4); tx_frame(14'h1234, 16, 4); end
      begin rx_frame(14'h3FFF, 14, 6, 4); rx_frame(14'h2222, 14, 16, 4); end
    join
    check(nvalid == vbefore + 1, "R7 one valid after restart", nvalid, vbefore + 1);
    check(rx_word == 14'h2222, "R7 restart word", rx_word, 14'h2222);

    // slow clocks, back to companded; R8 tx only then rx only
    mode = 2'b00;
    tx_frame(14'h0081, 16, 8);
    vbefore = nvalid;
    rx_frame(14'h0096, 8, 16, 8);
    check(nvalid == vbefore + 1, "R8 rx alone valid count", nvalid, vbefore + 1);
    check(rx_word == 14'h0096, "R2 upper bits zero", rx_word, 14'h0096);

    repeat (10) @(negedge clk);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule